// File: doc/BRIEF.md
# Page-buffered flash write sequencer

This block is the device-side write engine of a byte-wide non-volatile memory. A host drives an asynchronous bus: active-low chip select, output enable and write strobe, a 17-bit address and an 8-bit data path, split here into an input, an output and an output-drive enable. The block samples that bus with its own clock. Byte writes go into a 128-byte page buffer. While writes keep coming, the page stays open. Once the bus has been quiet for a set number of cycles, the block commits the whole page to an array model during a timed programming phase. Every byte slot that was not written in that load cycle is stored as FFh.

While programming runs, every read returns a status byte instead of array data. Bit 7 of that byte is the inverse of bit 7 of the last byte written, and bit 6 alternates from one read to the next. A host polls either bit to find out when the commit has finished. All intervals are parameters counted in clock cycles. The array model keeps `2**ARR_PG_W` pages and uses the low page-address bits to pick one.

Top module: `pfw_page_writer`

## Requirements
- R1: Address bits 16..7 form the page number and bits 6..0 the byte slot within the page. The array keeps the low ARR_PG_W page bits, so pages that differ only above those bits share storage, while pages that differ within them are independent.
- R2: Slots may be written in any order. Every slot not written in the current load cycle reads back as FFh once the page has been committed, even if it held other data before.
- R3: A write latches the address when the write condition begins, which is the later of the chip-select and write-strobe falling edges. It latches the data when the write condition ends, which is the earlier of their rising edges.
- R4: Each accepted write restarts the inactivity timer. Writes to the same page spaced fewer than T_BLCO cycles apart all land in the same load cycle.
- R5: After T_BLCO cycles with no accepted write, programming starts. Before that point, reads still return array contents. Programming lasts T_PROG cycles, after which reads return the committed data.
- R6: During programming, any read returns the inverse of bit 7 of the last byte written, and bits 5..0 of that byte unchanged.
- R7: During programming, bit 6 of the first read is 0, and it inverts after each completed read.
- R8: A write strobe while output enable is low, or while chip select is high, loads nothing.
- R9: The output-drive enable is low whenever chip select or output enable is high.
- R10: A write to a page other than the open one is ignored and does not restart the inactivity timer.
- R11: Writes that arrive during programming are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ce_n | input | 1 | chip select, active low |
| oe_n | input | 1 | output enable, active low |
| we_n | input | 1 | write strobe, active low |
| addr | input | 17 | byte address |
| dq_i | input | 8 | write data from the host |
| dq_o | output | 8 | read data or status byte |
| dq_oe | output | 1 | drive enable for dq_o |

## Verification
Every bus line passes through two synchronizer stages. The drive enable therefore follows a read strobe after 2 cycles, and array data follows one registered array read later, so 3 cycles in all. The bench holds each read for 6 cycles and samples at the falling edge. Programming begins T_BLCO cycles after the last accepted write, plus the sync delay. The bench places its reads either well inside that window or well beyond it. For example, the ignored-write check samples at a point that falls after the timeout if the foreign write was dropped, and before it if that write wrongly restarted the timer. Commit results are read only after T_BLCO plus T_PROG plus a margin has elapsed.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pfw_state_e;
endpackage

// File: rtl/pfw_bus_sync.sv
module pfw_bus_sync #(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              wr_end,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_act,
   output logic              rd_end,
   output logic [ADDR_W-1:0] addr_s
);
   localparam int BUS_W = 3 + ADDR_W + DATA_W;
   localparam logic [BUS_W-1:0] RST_V = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pfw_bus_sync: SYNC_STAGES must be at least 2");
   end

   logic [BUS_W-1:0] stg [SYNC_STAGES];
   logic             ce_s, oe_s, we_s;
   logic [DATA_W-1:0] din_s;
   logic             wr_act, wr_q, rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= RST_V;
      end else begin
         stg[0] <= {ce_n, oe_n, we_n, addr, din};
         for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign {ce_s, oe_s, we_s, addr_s, din_s} = stg[SYNC_STAGES-1];

   // write condition: select and strobe low, outputs disabled
   assign wr_act = !ce_s && !we_s && oe_s;
   assign rd_act = !ce_s && !oe_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_q <= wr_act;
         rd_q <= rd_act;
         if (wr_act && !wr_q) wr_addr <= addr_s;   // later falling edge
         if (wr_act)          wr_data <= din_s;    // frozen at earlier rising edge
      end
   end

   assign wr_end = wr_q && !wr_act;
   assign rd_end = rd_q && !rd_act;

   // R3: the address only moves at the start of a write condition
   a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_act && !wr_q) |=> $stable(wr_addr));
endmodule

// File: rtl/pfw_page_buf.sv
module pfw_page_buf #(
   parameter int IDX_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_first,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_dat,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_dat
);
   localparam int SLOTS = 1 << IDX_W;

   logic [DATA_W-1:0] slot [SLOTS];
   logic [SLOTS-1:0]  vld;

   always_ff @(posedge clk) begin
      if (wr_en) slot[wr_idx] <= wr_dat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (wr_en) begin
         if (wr_first) vld <= '0;
         vld[wr_idx] <= 1'b1;
      end
   end

   // unloaded slots commit as erased
   assign rd_dat = vld[rd_idx] ? slot[rd_idx] : {DATA_W{1'b1}};

   // R2: a new load cycle forgets the previous one's slots
   a_r2_fresh_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_first) |=> $countones(vld) == 1);
endmodule

// File: rtl/pfw_ctrl.sv
module pfw_ctrl
   import pfw_pkg::*;
#(
   parameter int T_BLCO = 15000,
   parameter int T_PROG = 500000,
   parameter int PAGE_W = 10,
   parameter int IDX_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_end,
   input  logic [PAGE_W-1:0] wr_page,
   input  logic [DATA_W-1:0] wr_data,
   output logic              buf_we,
   output logic              buf_first,
   output logic              prog_we,
   output logic [IDX_W-1:0]  prog_idx,
   output logic              prog_start,
   output logic              in_prog,
   output logic [PAGE_W-1:0] page_q,
   output logic [DATA_W-1:0] last_byte
);
   localparam int SLOTS = 1 << IDX_W;
   localparam int T_MAX = (T_BLCO > T_PROG) ? T_BLCO : T_PROG;
   localparam int CNT_W = $clog2(T_MAX + 1);

   if (T_PROG < SLOTS) begin : g_bad_prog
      $error("pfw_ctrl: T_PROG must cover one cycle per page slot");
   end
   if (T_BLCO < 2) begin : g_bad_blco
      $error("pfw_ctrl: T_BLCO must be at least 2");
   end

   pfw_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             load_ok;

   assign load_ok    = wr_end && ((state == ST_IDLE) ||
                                  ((state == ST_LOAD) && (wr_page == page_q)));
   assign buf_we     = load_ok;
   assign buf_first  = (state == ST_IDLE);
   assign prog_start = (state == ST_LOAD) && !load_ok && (cnt == CNT_W'(T_BLCO - 1));
   assign in_prog    = (state == ST_PROG);
   assign prog_we    = in_prog && (cnt < CNT_W'(SLOTS));
   assign prog_idx   = cnt[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         page_q    <= '0;
         last_byte <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (load_ok) begin
                  state     <= ST_LOAD;
                  page_q    <= wr_page;
                  last_byte <= wr_data;
                  cnt       <= '0;
               end
            end
            ST_LOAD: begin
               if (load_ok) begin
                  last_byte <= wr_data;
                  cnt       <= '0;
               end else if (prog_start) begin
                  state <= ST_PROG;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PROG: begin
               if (cnt == CNT_W'(T_PROG - 1)) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5: programming is only ever entered from an open load cycle
   a_r5_prog_from_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_PROG) |-> $past(state == ST_LOAD));
   // R4: an accepted write keeps the cycle open with a fresh timer
   a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_end && state == ST_LOAD && wr_page == page_q) |=> (state == ST_LOAD && cnt == '0));
   // R10: the open page never changes inside a load cycle
   a_r10_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD && $past(state == ST_LOAD)) |-> $stable(page_q));
   // R11: a write during programming leaves the phase running
   a_r11_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROG && wr_end && cnt != CNT_W'(T_PROG - 1)) |=> state == ST_PROG);
endmodule

// File: rtl/pfw_array.sv
module pfw_array #(
   parameter int AW     = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdat,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdat
);
   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdat;
      rdat <= mem[raddr];
   end
endmodule

// File: rtl/pfw_page_writer.sv
module pfw_page_writer #(
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 8,
   parameter int IDX_W       = 7,
   parameter int ARR_PG_W    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int T_BLCO      = 15000,
   parameter int T_PROG      = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe
);
   localparam int PAGE_W = ADDR_W - IDX_W;
   localparam int ARR_AW = ARR_PG_W + IDX_W;

   if (ARR_PG_W < 1 || ARR_PG_W > PAGE_W) begin : g_bad_arr
      $error("pfw_page_writer: ARR_PG_W must lie within the page field");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("pfw_page_writer: status bits need DATA_W of at least 8");
   end

   logic              wr_end, rd_act, rd_end;
   logic [ADDR_W-1:0] wr_addr, addr_s;
   logic [DATA_W-1:0] wr_data, buf_rd, arr_rd, last_byte, status;
   logic              buf_we, buf_first, prog_we, prog_start, in_prog;
   logic [IDX_W-1:0]  prog_idx;
   logic [PAGE_W-1:0] page_q;
   logic              tog;
   logic [PAGE_W-ARR_PG_W:0] unused_hi;

   pfw_bus_sync #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(dq_i), .wr_end(wr_end), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_act(rd_act), .rd_end(rd_end), .addr_s(addr_s));

   pfw_ctrl #(.T_BLCO(T_BLCO), .T_PROG(T_PROG), .PAGE_W(PAGE_W), .IDX_W(IDX_W),
              .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .wr_page(wr_addr[ADDR_W-1:IDX_W]),
      .wr_data(wr_data), .buf_we(buf_we), .buf_first(buf_first), .prog_we(prog_we),
      .prog_idx(prog_idx), .prog_start(prog_start), .in_prog(in_prog),
      .page_q(page_q), .last_byte(last_byte));

   pfw_page_buf #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_first(buf_first),
      .wr_idx(wr_addr[IDX_W-1:0]), .wr_dat(wr_data), .rd_idx(prog_idx), .rd_dat(buf_rd));

   pfw_array #(.AW(ARR_AW), .DATA_W(DATA_W)) u_arr (
      .clk(clk), .we(prog_we), .waddr({page_q[ARR_PG_W-1:0], prog_idx}), .wdat(buf_rd),
      .raddr(addr_s[ARR_AW-1:0]), .rdat(arr_rd));

   // page bits above the stored range select nothing in the array model
   assign unused_hi = {addr_s[ADDR_W-1:ARR_AW], 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tog <= 1'b0;
      else if (prog_start)       tog <= 1'b0;
      else if (in_prog && rd_end) tog <= ~tog;
   end

   always_comb begin
      status    = last_byte;
      status[7] = ~last_byte[7];
      status[6] = tog;
   end

   assign dq_o  = in_prog ? status : arr_rd;
   assign dq_oe = rd_act;

   // R7: each completed read during programming flips the toggle bit
   a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (in_prog && rd_end && !prog_start) |=> tog != $past(tog));
   // R6: the polled bit is the inverse of the last written bit 7
   a_r6_poll: assert property (@(posedge clk) disable iff (!rst_n)
      in_prog |-> dq_o[7] != last_byte[7]);
   // R9: no drive while reads are not requested
   a_r9_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_act |-> !dq_oe);
endmodule

// File: tb/pfw_page_writer_tb.sv
module pfw_page_writer_tb;
   localparam int TB_BLCO = 40;
   localparam int TB_PROG = 300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [16:0] addr = '0;
   logic [7:0]  dq_i = '0;
   logic [7:0]  dq_o;
   logic        dq_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [8:0] exp_q [$];
   string      tag_q [$];
   event       smp_ev;

   always #10 clk = ~clk;

   pfw_page_writer #(.T_BLCO(TB_BLCO), .T_PROG(TB_PROG)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe));

   function automatic logic [16:0] mk(input int pg, input int idx);
      return {pg[9:0], idx[6:0]};
   endfunction

   function automatic logic [7:0] st(input logic [7:0] d, input logic t);
      return {~d[7], t, d[5:0]};
   endfunction

   task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard when a read is sampled
   initial begin
      forever begin
         @(smp_ev);
         check(tag_q.pop_front(), {dq_oe, dq_o}, exp_q.pop_front());
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_byte(input logic [16:0] a, input logic [7:0] d);
      addr = a; dq_i = d;
      ce_n = 1'b0; cyc(1);
      we_n = 1'b0; cyc(3);
      we_n = 1'b1; cyc(1);
      ce_n = 1'b1; cyc(2);
   endtask

   task automatic rd_exp(input logic [16:0] a, input logic [7:0] e, input string tag);
      exp_q.push_back({1'b1, e});
      tag_q.push_back(tag);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      cyc(6);
      -> smp_ev;
      #1;
      oe_n = 1'b1; ce_n = 1'b1;
      cyc(3);
   endtask

   task automatic wait_commit();
      cyc(TB_BLCO + TB_PROG + 30);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      cyc(3);
      check("R9 reset drive off", {dq_oe, 8'h00}, 9'h000);
      rst_n = 1'b1;
      cyc(3);

      // R2 out-of-order loads, R6/R7 status reads
      wr_byte(mk(3, 5),   8'h3C);
      wr_byte(mk(3, 2),   8'hA5);
      wr_byte(mk(3, 127), 8'h81);
      cyc(TB_BLCO + 10);
      rd_exp(mk(3, 0), st(8'h81, 1'b0), "R6 R7 first status read");
      rd_exp(mk(3, 0), st(8'h81, 1'b1), "R7 second status read toggles");
      addr = mk(3, 0); ce_n = 1'b0; cyc(4);
      check("R9 select without output enable", {dq_oe, 8'h00}, 9'h000);
      ce_n = 1'b1;
      wait_commit();
      rd_exp(mk(3, 5),   8'h3C, "R2 slot 5");
      rd_exp(mk(3, 2),   8'hA5, "R2 slot 2");
      rd_exp(mk(3, 127), 8'h81, "R5 slot 127 after commit");
      rd_exp(mk(3, 0),   8'hFF, "R2 unloaded slot 0");
      rd_exp(mk(3, 100), 8'hFF, "R2 unloaded slot 100");

      // R1 page split and aliasing
      wr_byte(mk(4, 0), 8'h11);
      wait_commit();
      rd_exp(mk(4, 0),  8'h11, "R1 page 4 slot 0");
      rd_exp(mk(3, 0),  8'hFF, "R1 page 3 untouched by page 4");
      rd_exp(mk(19, 5), 8'h3C, "R1 page 19 aliases page 3");

      // R3 select-controlled write: later fall latches address, earlier rise latches data
      addr = mk(5, 9); dq_i = 8'h5A;
      we_n = 1'b0; cyc(3);
      addr = mk(5, 10); cyc(3);
      ce_n = 1'b0; cyc(3);
      ce_n = 1'b1; cyc(3);
      dq_i = 8'h00; cyc(3);
      we_n = 1'b1; cyc(2);
      wait_commit();
      rd_exp(mk(5, 10), 8'h5A, "R3 address and data latch edges");
      rd_exp(mk(5, 9),  8'hFF, "R3 early address not used");

      // R8 write inhibited by output enable low
      wr_byte(mk(6, 0), 8'h77);
      addr = mk(6, 1); dq_i = 8'h12;
      ce_n = 1'b0; oe_n = 1'b0; cyc(1);
      we_n = 1'b0; cyc(3);
      we_n = 1'b1; cyc(1);
      ce_n = 1'b1; oe_n = 1'b1; cyc(2);
      wait_commit();
      rd_exp(mk(6, 0), 8'h77, "R8 normal write kept");
      rd_exp(mk(6, 1), 8'hFF, "R8 inhibited write not loaded");

      // R10 foreign page ignored and timer not restarted
      wr_byte(mk(7, 0), 8'h99);
      cyc(12);
      wr_byte(mk(8, 0), 8'h44);
      cyc(30);
      rd_exp(mk(7, 0), st(8'h99, 1'b0), "R10 timeout not restarted");
      // R11 write during programming
      wr_byte(mk(7, 1), 8'h22);
      wait_commit();
      rd_exp(mk(7, 0), 8'h99, "R10 foreign data not merged");
      rd_exp(mk(7, 1), 8'hFF, "R11 write during programming ignored");

      // R4 spaced loads stay in one cycle
      for (int i = 0; i < 4; i++) begin
         wr_byte(mk(9, i), 8'hC0 + 8'(i));
         cyc(25);
      end
      wait_commit();
      for (int i = 0; i < 4; i++) begin
         rd_exp(mk(9, i), 8'hC0 + 8'(i), $sformatf("R4 spaced slot %0d", i));
      end

      // R5 array readable before timeout, R2 reload erases omitted slots
      wr_byte(mk(3, 5), 8'hC3);
      rd_exp(mk(3, 2), 8'hA5, "R5 array data before timeout");
      wait_commit();
      rd_exp(mk(3, 5), 8'hC3, "R5 new data after commit");
      rd_exp(mk(3, 2), 8'hFF, "R2 omitted slot erased on reload");

      cyc(5);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule